// File: doc/BRIEF.md
# Disk Sector Serial Datapath

This block is the bit-level datapath between a memory DMA port and the serial head signal of a fixed-format disk sector. In write mode it produces the whole sector as one serial stream. The stream starts with a zero-byte preamble and a marker byte. It then carries every payload byte followed by an odd parity bit, and it ends with a run of zero bytes. Payload bytes are fetched one at a time over a request/acknowledge port. If a byte is not available when it is due, the block writes a zero byte in its place and raises an underrun flag.

In read mode the block may be started anywhere inside the preamble. It searches the incoming bits for a run of zeros followed by the marker and aligns itself on the bit after the marker. It then cuts the stream into 9-bit groups, checks each group's parity, and offers each byte on the DMA port. If no marker is found within a bounded number of bit times, it stops and flags a sync timeout.

One serial bit moves per `bit_tick` pulse in both directions. Status flags are held until the next accepted start.

Top module: `dsk_sector_io`

## Requirements
- R1: After reset, `busy`, `wr_gate`, `wr_bit`, `dma_req`, `blk_done`, `parity_err`, `sync_timeout` and `underrun` are all 0.
- R2: A write stream begins with 15 bytes of 0x00 and then the marker 0xA1. Every byte is sent most significant bit first.
- R3: After the marker, each of the 232 payload bytes is sent as 8 data bits, MSB first, followed by one bit that makes the 9-bit group odd parity. Then 64 zero bits follow. `wr_gate` is high for exactly these 2280 bit times.
- R4: In write mode `dma_req` stays high until `dma_ack` is seen. Each acknowledge transfers one byte on `dma_wdata`. Exactly 232 bytes are requested per sector.
- R5: A payload slot whose byte has not arrived by the time it starts is sent as 0x00 with parity bit 1, and `underrun` is set.
- R6: `blk_done` is set once a write stream has finished, or once the 232nd byte has been framed in read mode.
- R7: In read mode, lock happens on the tick whose sample completes at least 8 consecutive zero bits followed by 0xA1. The search may begin at any bit of the preamble. With only 7 zeros before the marker, there is no lock.
- R8: After lock, each group of 9 sampled bits yields its first 8 bits (MSB first) as a byte on `dma_rdata`. `dma_req` is raised with the byte and cleared by `dma_ack`.
- R9: A 9-bit group with even parity sets `parity_err`. The flag stays set to the end of the sector and is cleared by the next accepted start.
- R10: If no lock occurs within 192 bit ticks of a read start, `sync_timeout` is set and the block goes idle without setting `blk_done`. A lock on tick 192 still counts.
- R11: `start_wr` and `start_rd` are ignored while `busy` is high. `start_wr` wins if both are raised together while idle.
- R12: Serial bits advance and are sampled only on cycles with `bit_tick` high. After a write start, `wr_gate` stays low until the first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_wr | input | 1 | Start writing one sector |
| start_rd | input | 1 | Start reading one sector |
| bit_tick | input | 1 | Bit-cell strobe, one serial bit per pulse |
| rd_bit | input | 1 | Serial read data, sampled on ticks |
| wr_bit | output | 1 | Serial write data |
| wr_gate | output | 1 | High while `wr_bit` carries a sector bit |
| dma_req | output | 1 | Byte transfer request |
| dma_ack | input | 1 | Byte transfer acknowledge |
| dma_wdata | input | 8 | Payload byte from memory (write mode) |
| dma_rdata | output | 8 | Payload byte to memory (read mode) |
| busy | output | 1 | A sector operation or transfer is in progress |
| blk_done | output | 1 | Sector completed |
| parity_err | output | 1 | Sticky read parity failure |
| sync_timeout | output | 1 | Marker not found in time |
| underrun | output | 1 | Write byte arrived too late |

## Verification
Write mode is driven with random payloads. One run gets a prompt responder, and its stream is compared bit for bit against a model built in the bench. A second run has a responder that stops after 100 bytes, which exposes where the zero fill starts and whether its parity is right. Read mode is fed with the search starting at the first preamble bit, at a random bit inside the preamble, and with exactly 8 zeros. These runs separate true pattern detection from position counting. A run with a parity bit flipped in one group confirms that bad parity is detected and that the flag is cleared by the next start. Feeding 7 zeros before the marker and a stream of only zeros checks the lock threshold and the exact tick on which the timeout fires.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_HUNT, RX_DATA} rx_state_t;

  function automatic logic odd_fill(input logic [7:0] b);
    return ~(^b);
  endfunction
endpackage

// File: rtl/dsk_ser_tx.sv
module dsk_ser_tx #(
  parameter int SYNC_BYTES = 16,
  parameter int DATA_BYTES = 232,
  parameter int TAIL_BYTES = 8,
  parameter logic [7:0] MARK = 8'hA1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       bit_tick,
  input  logic       ack,
  input  logic [7:0] wdata,
  output logic       busy,
  output logic       req,
  output logic       ser_bit,
  output logic       gate,
  output logic       done_p,
  output logic       underrun_p
);
  import dsk_pkg::*;

  localparam int TOTAL = SYNC_BYTES + DATA_BYTES + TAIL_BYTES;
  localparam int IW = $clog2(TOTAL + 1);
  localparam int FW = $clog2(DATA_BYTES + 1);
  localparam logic [IW-1:0] MARK_IDX = IW'(SYNC_BYTES - 1);
  localparam logic [IW-1:0] DATA_LO  = IW'(SYNC_BYTES);
  localparam logic [IW-1:0] DATA_HI  = IW'(SYNC_BYTES + DATA_BYTES);
  localparam logic [IW-1:0] END_IDX  = IW'(TOTAL);
  localparam logic [FW-1:0] FETCH_MAX = FW'(DATA_BYTES);

  logic [IW-1:0] idx_q;
  logic [3:0]    rem_q;
  logic [8:0]    sr_q;
  logic [FW-1:0] fetched_q;
  logic [7:0]    hold_q;
  logic          hold_full_q;

  logic          at_load, finish, in_data, need, take, starve, hold_full_n;
  logic [7:0]    pick;
  logic [8:0]    word;
  logic [FW-1:0] fetched_n;

  always_comb begin
    at_load     = busy && bit_tick && (rem_q == 4'd0);
    finish      = at_load && (idx_q == END_IDX);
    in_data     = (idx_q >= DATA_LO) && (idx_q < DATA_HI);
    need        = at_load && in_data;
    take        = req && ack;
    pick        = hold_full_q ? hold_q : (take ? wdata : 8'h00);
    starve      = need && !hold_full_q && !take;
    if (in_data)                word = {pick, odd_fill(pick)};
    else if (idx_q == MARK_IDX) word = {MARK, 1'b0};
    else                        word = 9'd0;
    hold_full_n = need ? 1'b0 : (take ? 1'b1 : hold_full_q);
    fetched_n   = fetched_q + FW'(take);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      req         <= 1'b0;
      ser_bit     <= 1'b0;
      gate        <= 1'b0;
      done_p      <= 1'b0;
      underrun_p  <= 1'b0;
      idx_q       <= '0;
      rem_q       <= '0;
      sr_q        <= '0;
      fetched_q   <= '0;
      hold_q      <= '0;
      hold_full_q <= 1'b0;
    end else begin
      done_p     <= 1'b0;
      underrun_p <= 1'b0;
      if (start && !busy) begin
        busy        <= 1'b1;
        idx_q       <= '0;
        rem_q       <= '0;
        gate        <= 1'b0;
        ser_bit     <= 1'b0;
        fetched_q   <= '0;
        hold_full_q <= 1'b0;
        req         <= (FETCH_MAX != '0);
      end else if (busy) begin
        if (take && !need) hold_q <= wdata;
        hold_full_q <= hold_full_n;
        fetched_q   <= fetched_n;
        req         <= !finish && !hold_full_n && (fetched_n < FETCH_MAX);
        if (starve) underrun_p <= 1'b1;
        if (finish) begin
          busy    <= 1'b0;
          gate    <= 1'b0;
          ser_bit <= 1'b0;
          done_p  <= 1'b1;
        end else if (at_load) begin
          gate    <= 1'b1;
          ser_bit <= word[8];
          sr_q    <= {word[7:0], 1'b0};
          rem_q   <= in_data ? 4'd8 : 4'd7;
          idx_q   <= idx_q + 1'b1;
        end else if (bit_tick) begin
          ser_bit <= sr_q[8];
          sr_q    <= {sr_q[7:0], 1'b0};
          rem_q   <= rem_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dsk_sync_rx.sv
module dsk_sync_rx #(
  parameter int DATA_BYTES    = 232,
  parameter int MIN_ZEROS     = 8,
  parameter int TIMEOUT_BYTES = 24,
  parameter logic [7:0] MARK  = 8'hA1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       bit_tick,
  input  logic       ser_in,
  input  logic       ack,
  output logic       busy,
  output logic       req,
  output logic [7:0] rdata,
  output logic       done_p,
  output logic       perr_p,
  output logic       tmo_p
);
  import dsk_pkg::*;

  localparam int HW = MIN_ZEROS + 8;
  localparam int TW = $clog2(TIMEOUT_BYTES * 8 + 1);
  localparam int BW = $clog2(DATA_BYTES + 1);
  localparam logic [TW-1:0] T_LAST  = TW'(TIMEOUT_BYTES * 8 - 1);
  localparam logic [BW-1:0] B_LAST  = BW'(DATA_BYTES - 1);
  localparam logic [HW-1:0] PATTERN = {{MIN_ZEROS{1'b0}}, MARK};

  rx_state_t     state_q;
  logic [HW-2:0] hist_q;
  logic [HW-1:0] nxt_hist;
  logic [TW-1:0] hunt_q;
  logic [3:0]    bitcnt_q;
  logic [7:0]    sr_q;
  logic [BW-1:0] bytes_q;

  assign nxt_hist = {hist_q, ser_in};
  assign busy     = (state_q != RX_IDLE) || req;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= RX_IDLE;
      hist_q   <= '1;
      hunt_q   <= '0;
      bitcnt_q <= '0;
      sr_q     <= '0;
      bytes_q  <= '0;
      req      <= 1'b0;
      rdata    <= '0;
      done_p   <= 1'b0;
      perr_p   <= 1'b0;
      tmo_p    <= 1'b0;
    end else begin
      done_p <= 1'b0;
      perr_p <= 1'b0;
      tmo_p  <= 1'b0;
      if (req && ack) req <= 1'b0;
      if (start && !busy) begin
        state_q  <= RX_HUNT;
        hist_q   <= '1;
        hunt_q   <= '0;
        bitcnt_q <= '0;
        bytes_q  <= '0;
      end else begin
        case (state_q)
          RX_HUNT: if (bit_tick) begin
            hist_q <= nxt_hist[HW-2:0];
            if (nxt_hist == PATTERN) begin
              state_q  <= RX_DATA;
              bitcnt_q <= '0;
            end else if (hunt_q == T_LAST) begin
              tmo_p   <= 1'b1;
              state_q <= RX_IDLE;
            end else begin
              hunt_q <= hunt_q + 1'b1;
            end
          end
          RX_DATA: if (bit_tick) begin
            if (bitcnt_q == 4'd8) begin
              rdata    <= sr_q;
              req      <= 1'b1;
              if (!(^{sr_q, ser_in})) perr_p <= 1'b1;
              bitcnt_q <= '0;
              bytes_q  <= bytes_q + 1'b1;
              if (bytes_q == B_LAST) begin
                state_q <= RX_IDLE;
                done_p  <= 1'b1;
              end
            end else begin
              sr_q     <= {sr_q[6:0], ser_in};
              bitcnt_q <= bitcnt_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dsk_sector_io.sv
module dsk_sector_io #(
  parameter int SYNC_BYTES    = 16,
  parameter int DATA_BYTES    = 232,
  parameter int TAIL_BYTES    = 8,
  parameter int MIN_ZEROS     = 8,
  parameter int TIMEOUT_BYTES = 24,
  parameter logic [7:0] MARK  = 8'hA1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_wr,
  input  logic       start_rd,
  input  logic       bit_tick,
  input  logic       rd_bit,
  output logic       wr_bit,
  output logic       wr_gate,
  output logic       dma_req,
  input  logic       dma_ack,
  input  logic [7:0] dma_wdata,
  output logic [7:0] dma_rdata,
  output logic       busy,
  output logic       blk_done,
  output logic       parity_err,
  output logic       sync_timeout,
  output logic       underrun
);
  logic tx_busy, tx_req, tx_done, tx_un;
  logic rx_busy, rx_req, rx_done, rx_perr, rx_tmo;
  logic acc_wr, acc_rd;

  assign busy    = tx_busy || rx_busy;
  assign acc_wr  = start_wr && !busy;
  assign acc_rd  = start_rd && !start_wr && !busy;
  assign dma_req = tx_req || rx_req;

  dsk_ser_tx #(
    .SYNC_BYTES(SYNC_BYTES), .DATA_BYTES(DATA_BYTES),
    .TAIL_BYTES(TAIL_BYTES), .MARK(MARK)
  ) u_tx (
    .clk(clk), .rst(rst), .start(acc_wr), .bit_tick(bit_tick),
    .ack(dma_ack && tx_req), .wdata(dma_wdata), .busy(tx_busy),
    .req(tx_req), .ser_bit(wr_bit), .gate(wr_gate),
    .done_p(tx_done), .underrun_p(tx_un)
  );

  dsk_sync_rx #(
    .DATA_BYTES(DATA_BYTES), .MIN_ZEROS(MIN_ZEROS),
    .TIMEOUT_BYTES(TIMEOUT_BYTES), .MARK(MARK)
  ) u_rx (
    .clk(clk), .rst(rst), .start(acc_rd), .bit_tick(bit_tick),
    .ser_in(rd_bit), .ack(dma_ack && rx_req), .busy(rx_busy),
    .req(rx_req), .rdata(dma_rdata), .done_p(rx_done),
    .perr_p(rx_perr), .tmo_p(rx_tmo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_done     <= 1'b0;
      parity_err   <= 1'b0;
      sync_timeout <= 1'b0;
      underrun     <= 1'b0;
    end else if (acc_wr || acc_rd) begin
      blk_done     <= 1'b0;
      parity_err   <= 1'b0;
      sync_timeout <= 1'b0;
      underrun     <= 1'b0;
    end else begin
      if (tx_done || rx_done) blk_done     <= 1'b1;
      if (rx_perr)            parity_err   <= 1'b1;
      if (rx_tmo)             sync_timeout <= 1'b1;
      if (tx_un)              underrun     <= 1'b1;
    end
  end
endmodule

// File: rtl/dsk_sector_io_chk.sv
module dsk_sector_io_chk (
  input logic clk,
  input logic rst,
  input logic wr_gate,
  input logic dma_req,
  input logic dma_ack,
  input logic busy,
  input logic blk_done,
  input logic parity_err,
  input logic underrun
);
  // R4: a request is not withdrawn before its acknowledge while the operation runs
  assert_req_held_R4: assert property (@(posedge clk) disable iff (rst)
    (dma_req && !dma_ack) |=> (dma_req || !busy));

  // R3: the write gate only opens during an operation
  assert_gate_in_op_R3: assert property (@(posedge clk) disable iff (rst)
    wr_gate |-> busy);

  // R6: completion follows the end of the write stream
  assert_done_after_stream_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_gate) |=> blk_done);

  // R9: parity failure is held for the rest of the sector
  assert_perr_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (parity_err && busy) |=> parity_err);

  // R5: underrun only arises during an operation
  assert_underrun_in_op_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(underrun) |-> busy);
endmodule

bind dsk_sector_io dsk_sector_io_chk u_chk (
  .clk(clk), .rst(rst), .wr_gate(wr_gate), .dma_req(dma_req),
  .dma_ack(dma_ack), .busy(busy), .blk_done(blk_done),
  .parity_err(parity_err), .underrun(underrun)
);

// File: tb/dsk_sector_io_test.sv
module dsk_sector_io_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_wr = 1'b0, start_rd = 1'b0, bit_tick = 1'b0, rd_bit = 1'b0;
  logic dma_ack = 1'b0;
  logic [7:0] dma_wdata = 8'h00;
  logic wr_bit, wr_gate, dma_req, busy, blk_done, parity_err, sync_timeout, underrun;
  logic [7:0] dma_rdata;

  int checks = 0, errors = 0;
  bit rd_mode = 0;
  bit ack_en = 1;
  int wlimit = 232;
  int widx = 0;
  int nrx = 0;
  int ng = 0;
  bit gate_in_read = 0;
  logic [7:0] wq [232];
  logic [7:0] rxq [232];
  logic got [2400];
  logic sbits [2600];
  int ns = 0;

  always #2 clk = ~clk;

  dsk_sector_io uut (
    .clk(clk), .rst(rst), .start_wr(start_wr), .start_rd(start_rd),
    .bit_tick(bit_tick), .rd_bit(rd_bit), .wr_bit(wr_bit), .wr_gate(wr_gate),
    .dma_req(dma_req), .dma_ack(dma_ack), .dma_wdata(dma_wdata),
    .dma_rdata(dma_rdata), .busy(busy), .blk_done(blk_done),
    .parity_err(parity_err), .sync_timeout(sync_timeout), .underrun(underrun)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // DMA responder
  initial begin
    forever begin
      @(negedge clk);
      if (dma_ack) dma_ack = 1'b0;
      else if (dma_req && ack_en) begin
        if (rd_mode) begin
          if (nrx < 232) rxq[nrx] = dma_rdata;
          nrx++;
          dma_ack = 1'b1;
        end else if (widx < wlimit) begin
          dma_wdata = wq[widx];
          widx++;
          dma_ack = 1'b1;
        end
      end
    end
  end

  task automatic tick(input logic b);
    rd_bit = b;
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    if (wr_gate) begin
      if (rd_mode) gate_in_read = 1;
      else begin
        if (ng < 2400) got[ng] = wr_bit;
        ng++;
      end
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_start(input bit wr);
    if (wr) start_wr = 1'b1; else start_rd = 1'b1;
    @(negedge clk);
    start_wr = 1'b0;
    start_rd = 1'b0;
  endtask

  function automatic logic exp_wbit(input int k, input int lim);
    logic [7:0] b;
    int j, p;
    if (k < 120) return 1'b0;
    if (k < 128) return 8'hA1 >> (127 - k);
    if (k < 128 + 2088) begin
      j = (k - 128) / 9;
      p = (k - 128) % 9;
      b = (j < lim) ? wq[j] : 8'h00;
      if (p < 8) return b[7 - p];
      return ~(^b);
    end
    return 1'b0;
  endfunction

  task automatic run_write(input int lim, input bit poke_rd);
    int bad;
    int sync_bad, data_bad, tail_bad;
    bad = 0; sync_bad = 0; data_bad = 0; tail_bad = 0;
    for (int i = 0; i < 232; i++) wq[i] = 8'($urandom);
    rd_mode = 0; wlimit = lim; widx = 0; ng = 0;
    pulse_start(1);
    repeat (20) @(negedge clk);
    chk(wr_gate == 1'b0 && busy == 1'b1, "R12 no bit before first tick", int'(wr_gate), 0);
    for (int t = 0; t < 2400 && busy; t++) begin
      tick(1'b0);
      if (poke_rd && t == 500) pulse_start(0);
    end
    repeat (4) @(negedge clk);
    chk(ng == 2280, "R3 gated bit count", ng, 2280);
    for (int k = 0; k < 2280 && k < ng; k++) begin
      if (got[k] !== exp_wbit(k, lim)) begin
        if (k < 128) sync_bad++;
        else if (k < 2216) data_bad++;
        else tail_bad++;
      end
    end
    chk(sync_bad == 0, "R2 preamble and marker bits", sync_bad, 0);
    chk(data_bad == 0, "R3 payload and parity bits", data_bad, 0);
    chk(tail_bad == 0, "R3 trailing zero bits", tail_bad, 0);
    chk(widx == lim, "R4 bytes transferred", widx, lim);
    chk(blk_done == 1'b1, "R6 done after write", int'(blk_done), 1);
    chk(underrun == (lim < 232), "R5 underrun flag", int'(underrun), int'(lim < 232));
    if (poke_rd) chk(sync_timeout == 1'b0 && nrx == 0, "R11 read start ignored during write", nrx, 0);
  endtask

  task automatic build_read(input int nz, input bit with_data, input int bad_idx);
    ns = 0;
    for (int i = 0; i < nz; i++) begin sbits[ns] = 1'b0; ns++; end
    for (int i = 7; i >= 0; i--) begin sbits[ns] = 8'hA1 >> i; ns++; end
    for (int j = 0; j < 232; j++) begin
      wq[j] = 8'($urandom);
      for (int i = 7; i >= 0; i--) begin
        sbits[ns] = with_data ? wq[j][i] : 1'b1; ns++;
      end
      sbits[ns] = with_data ? (~(^wq[j]) ^ (j == bad_idx)) : 1'b1; ns++;
    end
    for (int i = 0; i < 64; i++) begin sbits[ns] = 1'b0; ns++; end
  endtask

  task automatic run_read(input int nz, input int bad_idx, input string tag);
    int mism;
    mism = 0;
    build_read(nz, 1, bad_idx);
    rd_mode = 1; nrx = 0; gate_in_read = 0;
    pulse_start(0);
    for (int k = 0; k < ns; k++) begin
      tick(sbits[k]);
      if (k == 300) pulse_start(1);
    end
    repeat (10) @(negedge clk);
    chk(nrx == 232, {tag, " R8 bytes delivered"}, nrx, 232);
    for (int j = 0; j < 232 && j < nrx; j++) if (rxq[j] !== wq[j]) mism++;
    chk(mism == 0, {tag, " R7 R8 byte alignment"}, mism, 0);
    chk(parity_err == (bad_idx >= 0), {tag, " R9 parity flag"}, int'(parity_err), int'(bad_idx >= 0));
    chk(blk_done == 1'b1 && busy == 1'b0, {tag, " R6 done after read"}, int'(blk_done), 1);
    chk(gate_in_read == 0, {tag, " R11 write start ignored during read"}, int'(gate_in_read), 0);
  endtask

  initial begin
    void'($urandom(32'd1974));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, wr_gate, wr_bit, dma_req, blk_done, parity_err, sync_timeout, underrun} == 8'd0,
        "R1 reset state", int'({busy, wr_gate, wr_bit, dma_req}), 0);

    run_write(232, 1);
    run_write(100, 0);

    run_read(120, 57, "full-preamble");
    run_read(8 + int'($urandom % 112), -1, "mid-preamble");
    run_read(8, 3, "eight-zeros");

    // R7 boundary: seven zeros, marker, then ones -> no lock, timeout
    build_read(7, 0, -1);
    rd_mode = 1; nrx = 0;
    pulse_start(0);
    for (int k = 0; k < 300 && busy; k++) tick(sbits[k]);
    chk(sync_timeout == 1'b1 && nrx == 0, "R7 seven zeros do not lock", nrx, 0);
    chk(blk_done == 1'b0, "R10 no done on timeout", int'(blk_done), 0);

    // R10 exact tick of the timeout
    pulse_start(0);
    chk(sync_timeout == 1'b0, "R9 R10 flags cleared by start", int'(sync_timeout), 0);
    for (int k = 0; k < 191; k++) tick(1'b0);
    chk(sync_timeout == 1'b0 && busy == 1'b1, "R10 still hunting after 191 ticks", int'(sync_timeout), 0);
    tick(1'b0);
    chk(sync_timeout == 1'b1 && busy == 1'b0, "R10 timeout on tick 192", int'(sync_timeout), 1);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end
endmodule